// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor's word-wide load/store port and a main memory that moves whole lines. Each word address is cut into three fields: the low bits pick a word inside a line, the middle bits pick exactly one cache line, and the remaining high bits form the tag. The tag held by the selected line is compared with the request's tag, and that single comparison decides hit or miss.

The cache is write-back and allocates on both loads and stores. Each line carries a valid flag and a dirty flag. On a miss, a dirty resident line is first copied out to memory, then the target line is fetched. The fetched line is installed in the same cycle that the load word is returned, or that the store word is merged into it. The processor holds its request until it sees a one-cycle ready pulse. Memory holds its request until it sees a one-cycle acknowledge.

Top module: `dm_wb_cache`

## Requirements
- R1: The word address splits as offset = bits [OFF_W-1:0], line index = the next IDX_W bits, and tag = the remaining high bits. Every line index holds its own line independently of the others.
- R2: A load miss on a clean or empty line issues exactly one memory read (mem_we=0) of line address {tag, index}. It raises cpu_ready in the acknowledge cycle, with the requested word of mem_rdata on cpu_rdata.
- R3: A load hit raises cpu_ready in the same cycle the request is seen, with no memory request.
- R4: A store hit changes only the addressed word of the line, issues no memory traffic, and marks the line dirty.
- R5: Evicting a dirty line first issues a memory write (mem_we=1) to line address {stored tag, index} carrying the whole line, and only then issues the fill read.
- R6: Evicting a clean line issues no memory write.
- R7: A store miss fetches the full target line and overwrites only the addressed word. If the victim was dirty, the victim is written back first.
- R8: Two addresses with equal index and different tags displace each other on every alternate access, even while all other lines are empty.
- R9: Reset clears every valid flag, so the first access to any line misses whatever its address.
- R10: cpu_ready stays low from the start of a miss until the access completes, and it is never high while a write-back is in progress.
- R11: Once mem_req rises, mem_req, mem_we and mem_addr hold steady until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory line transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = fill |
| mem_addr | output | ADDR_W-OFF_W | Line address |
| mem_wdata | output | DATA_W*WORDS | Victim line data |
| mem_rdata | input | DATA_W*WORDS | Fill line data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle transfer completion |

## Verification
The properties assume that memory raises mem_ack only while mem_req is high, for a single cycle, and that the processor keeps cpu_req and its fields steady until cpu_ready. The bench memory model acknowledges after a fixed delay and only in answer to a pending request. The processor-side tasks drive a request at a falling edge and release it at the first falling edge after the ready pulse. Under those conditions, transfer stability and the write-back-then-fill ordering can be stated purely at the ports.

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int LADR_W = ADDR_W - OFF_W,
  localparam int LINE_W = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [LADR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  typedef enum logic [1:0] {S_LOOK, S_WBACK, S_FILL} state_t;
  state_t state;

  logic [LINE_W-1:0] line_q  [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [LINES-1:0]  valid_q, dirty_q;

  wire [OFF_W-1:0] off = cpu_addr[OFF_W-1:0];
  wire [IDX_W-1:0] idx = cpu_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] tag = cpu_addr[ADDR_W-1 -: TAG_W];

  wire hit      = valid_q[idx] && (tag_q[idx] == tag);
  wire look_hit = (state == S_LOOK) && cpu_req && hit;
  wire fill_end = (state == S_FILL) && mem_ack;

  logic [LINE_W-1:0] fill_line, hit_line;
  always_comb begin
    fill_line = mem_rdata;
    hit_line  = line_q[idx];
    if (cpu_we) begin
      fill_line[off*DATA_W +: DATA_W] = cpu_wdata;
      hit_line[off*DATA_W +: DATA_W]  = cpu_wdata;
    end
  end

  assign cpu_ready = look_hit || fill_end;
  assign cpu_rdata = (state == S_FILL) ? mem_rdata[off*DATA_W +: DATA_W]
                                       : line_q[idx][off*DATA_W +: DATA_W];
  assign mem_req   = (state != S_LOOK);
  assign mem_we    = (state == S_WBACK);
  assign mem_addr  = (state == S_WBACK) ? {tag_q[idx], idx} : {tag, idx};
  assign mem_wdata = line_q[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_LOOK;
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      case (state)
        S_LOOK: if (cpu_req) begin
          if (hit) begin
            if (cpu_we) dirty_q[idx] <= 1'b1;
          end else begin
            state <= (valid_q[idx] && dirty_q[idx]) ? S_WBACK : S_FILL;
          end
        end
        S_WBACK: if (mem_ack) state <= S_FILL;
        S_FILL: if (mem_ack) begin
          valid_q[idx] <= 1'b1;
          dirty_q[idx] <= cpu_we;
          state        <= S_LOOK;
        end
        default: state <= S_LOOK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (look_hit && cpu_we) line_q[idx] <= hit_line;
    if (fill_end) begin
      line_q[idx] <= fill_line;
      tag_q[idx]  <= tag;
    end
  end

endmodule

// File: rtl/dm_wb_cache_chk.sv
module dm_wb_cache_chk #(
  parameter int LADR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [LADR_W-1:0] mem_addr,
  input logic              mem_ack
);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr));

  assert_hit_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (!mem_req || mem_ack));

  assert_no_ready_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !(mem_req && mem_we));

  assert_ready_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  assert_wb_then_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

endmodule

bind dm_wb_cache dm_wb_cache_chk #(.LADR_W(LADR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/dm_wb_cache_tb.sv
module dm_wb_cache_tb_top;
  localparam int ADDR_W = 10, DATA_W = 32, LINES = 8, WORDS = 4;
  localparam int OFF_W = 2, IDX_W = 3, TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int LADR_W = ADDR_W - OFF_W, LINE_W = DATA_W * WORDS;
  localparam int NW = 2 ** ADDR_W;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_ready, mem_req, mem_we, mem_ack = 0;
  logic [LADR_W-1:0] mem_addr;
  logic [LINE_W-1:0] mem_wdata, mem_rdata = '0;

  always #2.5 clk = ~clk;

  dm_wb_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  logic [DATA_W-1:0] mem_arr [NW];
  logic [DATA_W-1:0] ref_mem [NW];
  int n_cmp = 0, n_bad = 0, wb_cnt = 0, fill_cnt = 0, wait_cnt = 0;
  logic [LADR_W-1:0] last_wb_addr = '0;

  initial for (int i = 0; i < NW; i++) begin
    mem_arr[i] = (i * 32'h0101_0101) ^ 32'hA500_0000;
    ref_mem[i] = mem_arr[i];
  end

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      wait_cnt <= wait_cnt + 1;
      if (wait_cnt == 2) begin
        wait_cnt <= 0;
        mem_ack  <= 1'b1;
        if (mem_we) begin
          for (int w = 0; w < WORDS; w++)
            mem_arr[{mem_addr, w[OFF_W-1:0]}] <= mem_wdata[w*DATA_W +: DATA_W];
          wb_cnt <= wb_cnt + 1;
          last_wb_addr <= mem_addr;
        end else begin
          for (int w = 0; w < WORDS; w++)
            mem_rdata[w*DATA_W +: DATA_W] <= mem_arr[{mem_addr, w[OFF_W-1:0]}];
          fill_cnt <= fill_cnt + 1;
        end
      end
    end
  end

  function automatic logic [ADDR_W-1:0] mk(int t, int i, int o);
    return {t[TAG_W-1:0], i[IDX_W-1:0], o[OFF_W-1:0]};
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] wd, output logic [DATA_W-1:0] rd,
                        output int lat);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; lat = 0;
    #1;
    while (!cpu_ready && lat < 60) begin
      @(negedge clk); #1; lat++;
    end
    rd = cpu_rdata;
    if (we) ref_mem[a] = wd;
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
  endtask

  logic [DATA_W-1:0] rd;
  int lat, f0, w0;

  task automatic t_reset;
    #1;
    chk("R9 reset ready", {31'b0, cpu_ready}, 0);
    chk("R9 reset mem_req", {31'b0, mem_req}, 0);
  endtask

  task automatic t_cold_read;
    f0 = fill_cnt; w0 = wb_cnt;
    access(0, mk(0, 0, 2), 0, rd, lat);
    chk("R2 cold read data", rd, ref_mem[mk(0, 0, 2)]);
    chk("R9 tag0 misses after reset", fill_cnt - f0, 1);
    chk("R6 no write-back on empty line", wb_cnt - w0, 0);
    chk("R10 ready held low on miss", {31'b0, lat > 0}, 1);
  endtask

  task automatic t_hits;
    f0 = fill_cnt;
    for (int o = 0; o < WORDS; o++) begin
      access(0, mk(0, 0, o), 0, rd, lat);
      chk("R3 hit data", rd, ref_mem[mk(0, 0, o)]);
      chk("R3 hit latency", lat, 0);
    end
    chk("R3 hits no fill", fill_cnt - f0, 0);
  endtask

  task automatic t_write_hit;
    f0 = fill_cnt; w0 = wb_cnt;
    access(1, mk(0, 0, 1), 32'hDEAD_0001, rd, lat);
    chk("R4 write hit latency", lat, 0);
    for (int o = 0; o < WORDS; o++) begin
      access(0, mk(0, 0, o), 0, rd, lat);
      chk("R4 line words after write", rd, ref_mem[mk(0, 0, o)]);
    end
    chk("R4 no memory traffic", (fill_cnt - f0) + (wb_cnt - w0), 0);
  endtask

  task automatic t_dirty_evict;
    f0 = fill_cnt; w0 = wb_cnt;
    access(0, mk(1, 0, 0), 0, rd, lat);
    chk("R5 evict read data", rd, ref_mem[mk(1, 0, 0)]);
    chk("R5 one write-back", wb_cnt - w0, 1);
    chk("R5 one fill", fill_cnt - f0, 1);
    chk("R5 write-back address", {24'b0, last_wb_addr}, {24'b0, mk(0, 0, 0) >> OFF_W});
    for (int o = 0; o < WORDS; o++)
      chk("R5 memory holds victim line", mem_arr[mk(0, 0, o)], ref_mem[mk(0, 0, o)]);
  endtask

  task automatic t_clean_evict;
    f0 = fill_cnt; w0 = wb_cnt;
    access(0, mk(0, 0, 1), 0, rd, lat);
    chk("R6 refetched data", rd, 32'hDEAD_0001);
    chk("R6 clean victim not written", wb_cnt - w0, 0);
    chk("R6 fill count", fill_cnt - f0, 1);
  endtask

  task automatic t_write_miss;
    f0 = fill_cnt; w0 = wb_cnt;
    access(1, mk(2, 1, 3), 32'hBEEF_0003, rd, lat);
    chk("R7 write miss fill", fill_cnt - f0, 1);
    chk("R7 write miss clean no wb", wb_cnt - w0, 0);
    chk("R10 write miss waits", {31'b0, lat > 0}, 1);
    for (int o = 0; o < WORDS; o++) begin
      access(0, mk(2, 1, o), 0, rd, lat);
      chk("R7 merged line", rd, ref_mem[mk(2, 1, o)]);
    end
    f0 = fill_cnt; w0 = wb_cnt;
    access(1, mk(3, 1, 0), 32'hBEEF_0100, rd, lat);
    chk("R7 dirty victim written", wb_cnt - w0, 1);
    chk("R7 fill after wb", fill_cnt - f0, 1);
    chk("R7 victim word in memory", mem_arr[mk(2, 1, 3)], 32'hBEEF_0003);
    access(0, mk(3, 1, 0), 0, rd, lat);
    chk("R7 stored word", rd, 32'hBEEF_0100);
    access(0, mk(3, 1, 2), 0, rd, lat);
    chk("R7 neighbour word from memory", rd, ref_mem[mk(3, 1, 2)]);
  endtask

  task automatic t_thrash;
    f0 = fill_cnt; w0 = wb_cnt;
    for (int k = 0; k < 6; k++) begin
      access(0, mk(4 + (k % 2), 2, k % WORDS), 0, rd, lat);
      chk("R8 alternating read data", rd, ref_mem[mk(4 + (k % 2), 2, k % WORDS)]);
    end
    chk("R8 every alternate access misses", fill_cnt - f0, 6);
    chk("R8 clean thrash no wb", wb_cnt - w0, 0);
    f0 = fill_cnt; w0 = wb_cnt;
    access(1, mk(4, 2, 0), 32'h1234_5678, rd, lat);
    access(0, mk(5, 2, 0), 0, rd, lat);
    chk("R8 conflicting read", rd, ref_mem[mk(5, 2, 0)]);
    chk("R8 dirty thrash wb", wb_cnt - w0, 1);
    chk("R8 dirty thrash fills", fill_cnt - f0, 2);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < LINES; i++)
      access(1, mk(6, i, i % WORDS), 32'h5000_0000 + i, rd, lat);
    f0 = fill_cnt;
    for (int i = 0; i < LINES; i++) begin
      access(0, mk(6, i, i % WORDS), 0, rd, lat);
      chk("R1 per-index data", rd, ref_mem[mk(6, i, i % WORDS)]);
    end
    chk("R1 lines independent", fill_cnt - f0, 0);
  endtask

  initial begin
    #500_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_cold_read;
    t_hits;
    t_write_hit;
    t_dirty_evict;
    t_clean_evict;
    t_write_miss;
    t_thrash;
    t_sweep;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule